// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of one 32-pin general-purpose I/O port. It keeps every per-pin setting that drives the pad ring. These settings are: whether the port or a peripheral owns the pin, the output enable, the pull-up, the pull-down, open-drain mode, input filtering and the filter type, a two-bit peripheral function code, and the output data latch. It also brings the pad input levels into the clock domain through a two-flop synchronizer so that software can read them.

Software reaches the bank through a simple word-addressed bus. For most attributes a write acts only on the bits that are 1 in the written mask. One address sets those bits and another clears them. A third, read-only address returns the current state. The output latch can also be written directly. A direct write only reaches pins that have been opted in through a separate direct-write-enable attribute, so a read-XOR-write toggle on one pin cannot disturb its neighbours. Reads are registered: the data for a read strobe appears on `bus_rdata` one clock later.

The address map is as follows. Attribute k (0 ownership, 1 output enable, 2 pull-up, 3 pull-down, 4 open-drain, 5 filter enable, 6 debounce type, 7 direct-write enable) sets at word 3k, clears at 3k+1 and reads its state at 3k+2. The output latch sets at 24, clears at 25, and reads or direct-writes at 26. The pin levels read at 27. Function-select bit 0 of all pins is read/write at 28, and bit 1 at 29.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is owned by the port (`pad_gpio_sel` all 1), pull-ups are on, output enable, pull-down, open-drain, filters, direct-write enable, output data and function select are all 0.
- R2: A write to an attribute's set word (3k) sets exactly the masked bits of that attribute and leaves the others unchanged. Every set word reads back as 0.
- R3: A write to an attribute's clear word (3k+1) clears exactly the masked bits and leaves the others unchanged. Every clear word reads back as 0.
- R4: An attribute's status word (3k+2) returns the attribute's current state, and writes to it have no effect.
- R5: A write to word 24 raises the masked bits of the output latch, and a write to word 25 lowers them. Bits outside the mask keep their level.
- R6: A direct write to word 26 updates only the latch bits whose direct-write enable (attribute 7) is 1. Word 26 reads back the latch.
- R7: Word 27 returns the pad inputs through two synchronizer flops. A change on `pad_in` shows up in the third read issued from the cycle of the change, and not in the first two.
- R8: Words 28 and 29 are read/write. Pin i's function code on `pad_func[2i+1:2i]` is {word29 bit i, word28 bit i}: 00 A, 01 B, 10 C, 11 D.
- R9: `pad_oe` bit i is 1 only when the port owns pin i and its output enable is 1. In open-drain mode it is also 0 while the latch bit is 1.
- R10: The filter enable (`pad_filt`) and the debounce type (`pad_deb`) are independent attributes. Changing one never alters the other.
- R11: Writes to words above 29 change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned next cycle |
| bus_addr | input | AW (6) | Word address |
| bus_wdata | input | N (32) | Write data / bit mask |
| bus_rdata | output | N (32) | Registered read data |
| pad_in | input | N (32) | Asynchronous pad input levels |
| pad_oe | output | N (32) | Pad output driver enable |
| pad_out | output | N (32) | Pad output level (latch) |
| pad_pu | output | N (32) | Pull-up enable |
| pad_pd | output | N (32) | Pull-down enable |
| pad_od | output | N (32) | Open-drain mode |
| pad_filt | output | N (32) | Input filter enable |
| pad_deb | output | N (32) | Filter type: 1 debounce, 0 glitch |
| pad_gpio_sel | output | N (32) | 1 = port owns pin, 0 = peripheral |
| pad_func | output | 2N (64) | Two-bit function code per pin |

## Verification
The bench builds the bank with its defaults: 32 pins and a 6-bit word address. With the full width, masks that reach pin 31 can be tested, as can a function code on several pins at once. With a 6-bit address, the unused words from 30 to 63 can be written and read to show that they hold nothing. The pin-level path is checked read by read around a pad change, which pins down the two-flop delay.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int NATTR    = 8;
    localparam int ATTR_CTL = 0;
    localparam int ATTR_OE  = 1;
    localparam int ATTR_PU  = 2;
    localparam int ATTR_PD  = 3;
    localparam int ATTR_OD  = 4;
    localparam int ATTR_FE  = 5;
    localparam int ATTR_DB  = 6;
    localparam int ATTR_DW  = 7;

    localparam int ADDR_OUT_SET = 3 * NATTR;
    localparam int ADDR_OUT_CLR = ADDR_OUT_SET + 1;
    localparam int ADDR_OUT_DAT = ADDR_OUT_SET + 2;
    localparam int ADDR_PINLVL  = ADDR_OUT_SET + 3;
    localparam int ADDR_FSEL0   = ADDR_OUT_SET + 4;
    localparam int ADDR_FSEL1   = ADDR_OUT_SET + 5;
    localparam int ADDR_LAST    = ADDR_FSEL1;

    function automatic bit attr_rst_one(int idx);
        return (idx == ATTR_CTL) || (idx == ATTR_PU);
    endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int W       = 32,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_VAL = RST_ONE ? {W{1'b1}} : {W{1'b0}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_stb) begin
            q <= (q & ~wr_mask) | (wdata & wr_mask);
        end else if (set_stb) begin
            q <= q | wdata;
        end else if (clr_stb) begin
            q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [N-1:0]   bus_wdata,
    output logic [N-1:0]   bus_rdata,
    input  logic [N-1:0]   pad_in,
    output logic [N-1:0]   pad_oe,
    output logic [N-1:0]   pad_out,
    output logic [N-1:0]   pad_pu,
    output logic [N-1:0]   pad_pd,
    output logic [N-1:0]   pad_od,
    output logic [N-1:0]   pad_filt,
    output logic [N-1:0]   pad_deb,
    output logic [N-1:0]   pad_gpio_sel,
    output logic [2*N-1:0] pad_func
);
    localparam int NFSEL = 2;

    logic [NATTR-1:0][N-1:0] attr_q;
    logic [NFSEL-1:0][N-1:0] fsel_q;
    logic [N-1:0]            out_q;
    logic [N-1:0]            lvl_q;
    logic [N-1:0]            rd_mux;

    // per-pin attribute registers with set / clear / status words
    for (genvar g = 0; g < NATTR; g++) begin : g_attr
        gpio_setclr_reg #(.W(N), .RST_ONE(attr_rst_one(g))) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (bus_wr && (bus_addr == AW'(3 * g))),
            .clr_stb (bus_wr && (bus_addr == AW'(3 * g + 1))),
            .wr_stb  (1'b0),
            .wr_mask ({N{1'b0}}),
            .wdata   (bus_wdata),
            .q       (attr_q[g])
        );
    end

    // output latch: set, clear, and direct write gated by attribute 7
    gpio_setclr_reg #(.W(N), .RST_ONE(1'b0)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_wr && (bus_addr == AW'(ADDR_OUT_SET))),
        .clr_stb (bus_wr && (bus_addr == AW'(ADDR_OUT_CLR))),
        .wr_stb  (bus_wr && (bus_addr == AW'(ADDR_OUT_DAT))),
        .wr_mask (attr_q[ATTR_DW]),
        .wdata   (bus_wdata),
        .q       (out_q)
    );

    // function-select planes: plain read/write words
    for (genvar k = 0; k < NFSEL; k++) begin : g_fsel
        gpio_setclr_reg #(.W(N), .RST_ONE(1'b0)) u_fsel (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (1'b0),
            .clr_stb (1'b0),
            .wr_stb  (bus_wr && (bus_addr == AW'(ADDR_FSEL0 + k))),
            .wr_mask ({N{1'b1}}),
            .wdata   (bus_wdata),
            .q       (fsel_q[k])
        );
    end

    gpio_sync2 #(.W(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl_q)
    );

    // read decode
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NATTR; i++) begin
            if (bus_addr == AW'(3 * i + 2)) begin
                rd_mux = attr_q[i];
            end
        end
        unique case (bus_addr)
            AW'(ADDR_OUT_DAT): rd_mux = out_q;
            AW'(ADDR_PINLVL):  rd_mux = lvl_q;
            AW'(ADDR_FSEL0):   rd_mux = fsel_q[0];
            AW'(ADDR_FSEL1):   rd_mux = fsel_q[1];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // pad controls
    assign pad_gpio_sel = attr_q[ATTR_CTL];
    assign pad_pu       = attr_q[ATTR_PU];
    assign pad_pd       = attr_q[ATTR_PD];
    assign pad_od       = attr_q[ATTR_OD];
    assign pad_filt     = attr_q[ATTR_FE];
    assign pad_deb      = attr_q[ATTR_DB];
    assign pad_out      = out_q;
    assign pad_oe       = attr_q[ATTR_CTL] & attr_q[ATTR_OE] & ~(attr_q[ATTR_OD] & out_q);

    for (genvar p = 0; p < N; p++) begin : g_func
        assign pad_func[2*p+1:2*p] = {fsel_q[1][p], fsel_q[0][p]};
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [N-1:0]   bus_wdata,
    input logic [N-1:0]   dw_mask,
    input logic [N-1:0]   pad_oe,
    input logic [N-1:0]   pad_out,
    input logic [N-1:0]   pad_pu,
    input logic [N-1:0]   pad_od,
    input logic [N-1:0]   pad_gpio_sel,
    input logic [2*N-1:0] pad_func
);
    assert_pu_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == AW'(3 * ATTR_PU)
        |=> pad_pu == ($past(pad_pu) | $past(bus_wdata)));

    assert_pu_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == AW'(3 * ATTR_PU + 1)
        |=> pad_pu == ($past(pad_pu) & ~$past(bus_wdata)));

    assert_out_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == AW'(ADDR_OUT_SET)
        |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

    assert_direct_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == AW'(ADDR_OUT_DAT)
        |=> pad_out == (($past(pad_out) & ~$past(dw_mask)) | ($past(bus_wdata) & $past(dw_mask))));

    assert_oe_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pad_gpio_sel) == '0);

    assert_oe_odrain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_od & pad_out) == '0);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr > AW'(ADDR_LAST)
        |=> $stable(pad_pu) && $stable(pad_out) && $stable(pad_func) && $stable(pad_gpio_sel));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .dw_mask      (attr_q[ATTR_DW]),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_pu       (pad_pu),
    .pad_od       (pad_od),
    .pad_gpio_sel (pad_gpio_sel),
    .pad_func     (pad_func)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
    localparam int N  = 32;
    localparam int AW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [N-1:0]   bus_wdata = '0;
    logic [N-1:0]   bus_rdata;
    logic [N-1:0]   pad_in = '0;
    logic [N-1:0]   pad_oe, pad_out, pad_pu, pad_pd, pad_od, pad_filt, pad_deb, pad_gpio_sel;
    logic [2*N-1:0] pad_func;

    int n_tests = 0;
    int n_fail  = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_d = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank #(.N(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_od(pad_od), .pad_filt(pad_filt), .pad_deb(pad_deb),
        .pad_gpio_sel(pad_gpio_sel), .pad_func(pad_func)
    );

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [N-1:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = AW'(a);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compare registered read data the cycle after each strobe
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            chk({32'h0, bus_rdata}, {32'h0, exp_q.pop_front()}, tag_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({32'h0, pad_gpio_sel}, {32'h0, 32'hFFFF_FFFF}, "R1 owner");
        chk({32'h0, pad_pu}, {32'h0, 32'hFFFF_FFFF}, "R1 pullup");
        chk({32'h0, pad_oe | pad_pd | pad_od | pad_filt | pad_deb | pad_out}, 64'h0, "R1 zeros");
        chk(pad_func, 64'h0, "R1 func");
        rd(2, 32'hFFFF_FFFF, "R1 owner status");
        rd(3 * 7 + 2, 32'h0, "R1 direct-write status");

        // R2 set only masked bits; set word reads zero
        wr(3, 32'h0000_00F0);
        rd(5, 32'h0000_00F0, "R2 oe status");
        wr(3, 32'h0000_0F00);
        rd(5, 32'h0000_0FF0, "R2 oe accumulate");
        rd(3, 32'h0, "R2 set word reads zero");
        chk({32'h0, pad_oe}, {32'h0, 32'h0000_0FF0}, "R2 pad_oe");

        // R3 clear only masked bits
        wr(7, 32'h0000_FFFF);
        chk({32'h0, pad_pu}, {32'h0, 32'hFFFF_0000}, "R3 pullup clear");
        rd(7, 32'h0, "R3 clear word reads zero");

        // R4 status write ignored, status reflects state
        wr(8, 32'h0);
        chk({32'h0, pad_pu}, {32'h0, 32'hFFFF_0000}, "R4 status write ignored");
        wr(9, 32'h8000_0001);
        rd(11, 32'h8000_0001, "R4 pulldown status");

        // R5 output set / clear
        wr(24, 32'h0000_00FF);
        wr(25, 32'h0000_000F);
        chk({32'h0, pad_out}, {32'h0, 32'h0000_00F0}, "R5 set/clear");
        rd(26, 32'h0000_00F0, "R5 latch readback");

        // R6 direct write gated by direct-write enable
        wr(26, 32'hFFFF_FFFF);
        chk({32'h0, pad_out}, {32'h0, 32'h0000_00F0}, "R6 no enable");
        wr(21, 32'h0000_0003);
        wr(26, 32'h0000_0001);
        chk({32'h0, pad_out}, {32'h0, 32'h0000_00F1}, "R6 enabled bits");
        wr(26, 32'h0000_00F1 ^ 32'h0000_0003);
        chk({32'h0, pad_out}, {32'h0, 32'h0000_00F2}, "R6 toggle");

        // R9 ownership and open-drain gating of pad_oe
        wr(12, 32'h0000_0030);
        chk({32'h0, pad_oe}, {32'h0, 32'h0000_0FC0}, "R9 open-drain high");
        wr(1, 32'h0000_0800);
        chk({32'h0, pad_oe}, {32'h0, 32'h0000_07C0}, "R9 peripheral owned");
        chk({32'h0, pad_gpio_sel}, {32'h0, 32'hFFFF_F7FF}, "R9 owner bit");

        // R10 filter enable and type are independent
        wr(15, 32'h0000_0100);
        chk({32'h0, pad_filt}, {32'h0, 32'h0000_0100}, "R10 filter on");
        chk({32'h0, pad_deb}, 64'h0, "R10 type untouched");
        wr(18, 32'h0000_0300);
        chk({32'h0, pad_deb}, {32'h0, 32'h0000_0300}, "R10 debounce");
        chk({32'h0, pad_filt}, {32'h0, 32'h0000_0100}, "R10 enable untouched");

        // R8 function select planes
        wr(28, 32'h0000_0005);
        wr(29, 32'h0000_0006);
        chk(pad_func, 64'h39, "R8 codes B C D");
        rd(29, 32'h0000_0006, "R8 plane1 readback");
        wr(29, 32'h8000_0000);
        chk(pad_func, 64'h8000_0000_0000_0011, "R8 pin31 code C");

        // R7 two-flop synchronised pin levels
        pad_in = 32'hA5A5_0001;
        rd(27, 32'h0, "R7 first read old");
        rd(27, 32'h0, "R7 second read old");
        rd(27, 32'hA5A5_0001, "R7 third read new");

        // R11 unmapped words
        wr(63, 32'hFFFF_FFFF);
        wr(30, 32'hFFFF_FFFF);
        chk({32'h0, pad_pu}, {32'h0, 32'hFFFF_0000}, "R11 pullup unchanged");
        chk({32'h0, pad_out}, {32'h0, 32'h0000_00F2}, "R11 latch unchanged");
        rd(63, 32'h0, "R11 unmapped read");

        repeat (3) @(negedge clk);
        chk({32'h0, 32'(exp_q.size())}, 64'h0, "scoreboard drained");
        finish_run();
    end
endmodule